// File: doc/BRIEF.md
# Descriptor Chain Walker

This block walks a linked list of transfer descriptors kept in shared memory and feeds each one to a DMA data mover. Software stores the byte address of the first descriptor through a start-register write port. The block then reads that descriptor with a single burst on an AXI read address/data channel pair and assembles the 256-bit record. It presents the source address, destination address, byte count, transfer ID and option bits on a valid/ready request port. After the request is accepted, it follows the record's link field to the next descriptor. A link value of all ones terminates the chain.

The data mover reports each finished transfer with a one-cycle completion pulse. Completions arrive in request order. A descriptor whose flag bit 0 is set produces a one-cycle interrupt pulse when its transfer completes. A parameter bounds how many accepted requests may still be waiting for completion while the walker fetches further ahead. Start writes that arrive while a chain is running wait in a small queue. A write that finds the queue full is dropped and sets a sticky error flag.

Top module: `dlist_fetch`

## Requirements
- R1: After reset, `stat_busy_o`, `stat_err_o`, `ar_valid_o`, `req_valid_o` and `irq_o` are all 0.
- R2: A start write with a non-zero address produces one read burst whose address is the start address with bits 4:0 cleared. The burst has length `256/DATA_W - 1` (3 for a 64-bit bus), size `log2(DATA_W/8)` (3) and burst type INCR (2'b01). `ar_valid_o` and `ar_addr_o` stay unchanged until `ar_ready_i` is seen.
- R3: Read beats fill the record from the bottom in arrival order. With a 64-bit bus the beats are: beat 0 = destination address, beat 1 = source address, beat 2 = link address, beat 3 = byte count in bits 31:0 and flags in bits 63:32. These fields appear on `req_dst_o`, `req_src_o` and `req_len_o`.
- R4: `req_id_o` equals flags[23:16] and `req_cfg_o` equals flags[15:0]. Flags bits 31:24 have no effect on any output.
- R5: While `req_valid_o` is 1 and `req_ready_i` is 0, the request stays valid and all its fields hold their values.
- R6: After a request is accepted, the block fetches the descriptor at the link address unless the link is 64'hFFFF_FFFF_FFFF_FFFF. For an all-ones link, no further read is issued for that chain.
- R7: A read burst is started only when at most NSPEC accepted requests lack a completion pulse (NSPEC defaults to 4). With NSPEC = 0, each fetch waits for the previous completion.
- R8: `irq_o` is high for exactly one cycle, in the cycle after a `done_i` pulse, and only when the completed descriptor (in request order) had flags bit 0 set.
- R9: `stat_busy_o` is 1 whenever a start address is queued, a descriptor is being fetched or offered, or an accepted request lacks completion. It is 0 once all of these are clear.
- R10: Start writes made while busy are queued in order, up to START_DEPTH entries (default 8). A non-zero write that finds the queue full is dropped and sets `stat_err_o`, which stays 1 until reset.
- R11: A start write with address 0 has no effect: no read is issued and `stat_busy_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_we_i | input | 1 | Start-register write strobe |
| start_addr_i | input | 64 | Address of the first descriptor of a chain |
| stat_busy_o | output | 1 | Status: chain work outstanding |
| stat_err_o | output | 1 | Status: a start write was dropped (sticky) |
| ar_valid_o | output | 1 | Read address valid |
| ar_ready_i | input | 1 | Read address ready |
| ar_addr_o | output | 64 | Read address (32-byte aligned) |
| ar_len_o | output | 8 | Burst length minus one |
| ar_size_o | output | 3 | Beat size code |
| ar_burst_o | output | 2 | Burst type (INCR) |
| r_valid_i | input | 1 | Read data valid |
| r_ready_o | output | 1 | Read data ready |
| r_data_i | input | DATA_W | Read data beat |
| req_valid_o | output | 1 | Transfer request valid |
| req_ready_i | input | 1 | Transfer request accepted |
| req_src_o | output | 64 | Source address |
| req_dst_o | output | 64 | Destination address |
| req_len_o | output | 32 | Byte count |
| req_id_o | output | 8 | Transfer ID (flags[23:16]) |
| req_cfg_o | output | 16 | Option bits (flags[15:0]) |
| done_i | input | 1 | One-cycle completion pulse from the data mover |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
The bench checks a start address with low bits set. A design that does not align it would fetch from the wrong location. It compares two descriptors that differ only in the reserved flag byte, which catches reserved bits leaking into the ID. It runs a seven-entry chain with completions withheld. A wrong speculation bound would show either a sixth fetch or fewer than five. A three-entry chain with interrupt flags 1, 0, 1 exposes any mismatch between completion order and interrupt order. Other tests hold the request port stalled, write address zero, and overfill the start queue by one. These catch, respectively, fields that drift under back-pressure, a spurious fetch from zero, and an overflow that is silently lost instead of flagged.

// File: rtl/dlist_pkg.sv
package dlist_pkg;

    localparam int DESC_W = 256;
    localparam int ADDR_W = 64;

    // Field order fixed by memory layout: dst at lowest bits, flags at highest.
    typedef struct packed {
        logic [31:0]       flags;
        logic [31:0]       len;
        logic [ADDR_W-1:0] nxt;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
    } dlist_desc_t;

    localparam logic [ADDR_W-1:0] CHAIN_END = '1;

    typedef enum logic [2:0] {
        W_IDLE,
        W_GATE,
        W_ADDR,
        W_BEAT,
        W_ISSUE
    } walk_state_e;

    typedef struct packed {
        logic err;
        logic irq;
    } top_regs_t;

endpackage

// File: rtl/dlist_fifo.sv
module dlist_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic                                  clk_i,
    input  logic                                  rst_ni,
    input  logic                                  push_i,
    input  logic [WIDTH-1:0]                      data_i,
    input  logic                                  pop_i,
    output logic [WIDTH-1:0]                      data_o,
    output logic                                  empty_o,
    output logic                                  full_o,
    output logic [$clog2(DEPTH+1)-1:0]            count_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [PW-1:0]               wp;
        logic [PW-1:0]               rp;
        logic [CW-1:0]               cnt;
    } fifo_regs_t;

    fifo_regs_t fifo_q, fifo_d;
    logic do_push, do_pop;

    always_comb begin
        fifo_d  = fifo_q;
        do_push = push_i && !full_o;
        do_pop  = pop_i && !empty_o;
        if (do_push) begin
            fifo_d.mem[fifo_q.wp] = data_i;
            fifo_d.wp = (fifo_q.wp == LAST) ? '0 : fifo_q.wp + 1'b1;
        end
        if (do_pop) begin
            fifo_d.rp = (fifo_q.rp == LAST) ? '0 : fifo_q.rp + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   fifo_d.cnt = fifo_q.cnt + 1'b1;
            2'b01:   fifo_d.cnt = fifo_q.cnt - 1'b1;
            default: fifo_d.cnt = fifo_q.cnt;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) fifo_q <= '0;
        else         fifo_q <= fifo_d;
    end

    assign data_o  = fifo_q.mem[fifo_q.rp];
    assign empty_o = (fifo_q.cnt == '0);
    assign full_o  = (fifo_q.cnt == CW'(DEPTH));
    assign count_o = fifo_q.cnt;

    // Callers gate their pushes (start queue: R10, pending flags: R7).
    assert_no_overflow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        push_i |-> !full_o);
    // Completions never outnumber accepted requests (R8).
    assert_no_underflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pop_i |-> !empty_o);

endmodule

// File: rtl/dlist_walker.sv
module dlist_walker
    import dlist_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 start_valid_i,
    input  logic [ADDR_W-1:0]    start_addr_i,
    output logic                 start_pop_o,
    input  logic                 fetch_ok_i,
    output logic                 ar_valid_o,
    input  logic                 ar_ready_i,
    output logic [ADDR_W-1:0]    ar_addr_o,
    output logic [7:0]           ar_len_o,
    output logic [2:0]           ar_size_o,
    output logic [1:0]           ar_burst_o,
    input  logic                 r_valid_i,
    input  logic [DATA_W-1:0]    r_data_i,
    output logic                 r_ready_o,
    output logic                 req_valid_o,
    input  logic                 req_ready_i,
    output dlist_desc_t          req_desc_o,
    output logic                 busy_o
);
    localparam int BEATS  = DESC_W / DATA_W;
    localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam int SIZE   = $clog2(DATA_W / 8);
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ADDR_W'(DESC_W / 8 - 1);

    typedef struct packed {
        walk_state_e         state;
        logic [ADDR_W-1:0]   ptr;
        logic [BEAT_W-1:0]   beat;
        logic [DESC_W-1:0]   rec;
    } walk_regs_t;

    walk_regs_t walk_q, walk_d;
    dlist_desc_t cur_desc;

    assign cur_desc = dlist_desc_t'(walk_q.rec);

    always_comb begin
        walk_d      = walk_q;
        start_pop_o = 1'b0;
        ar_valid_o  = 1'b0;
        r_ready_o   = 1'b0;
        req_valid_o = 1'b0;
        case (walk_q.state)
            W_IDLE: begin
                if (start_valid_i) begin
                    start_pop_o  = 1'b1;
                    walk_d.ptr   = start_addr_i;
                    walk_d.state = W_GATE;
                end
            end
            W_GATE: begin
                if (fetch_ok_i) walk_d.state = W_ADDR;
            end
            W_ADDR: begin
                ar_valid_o = 1'b1;
                if (ar_ready_i) begin
                    walk_d.beat  = '0;
                    walk_d.state = W_BEAT;
                end
            end
            W_BEAT: begin
                r_ready_o = 1'b1;
                if (r_valid_i) begin
                    walk_d.rec[int'(walk_q.beat) * DATA_W +: DATA_W] = r_data_i;
                    if (walk_q.beat == LAST_BEAT) walk_d.state = W_ISSUE;
                    else                          walk_d.beat  = walk_q.beat + 1'b1;
                end
            end
            W_ISSUE: begin
                req_valid_o = 1'b1;
                if (req_ready_i) begin
                    if (cur_desc.nxt == CHAIN_END) begin
                        walk_d.state = W_IDLE;
                    end else begin
                        walk_d.ptr   = cur_desc.nxt;
                        walk_d.state = W_GATE;
                    end
                end
            end
            default: walk_d.state = W_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            walk_q       <= '0;
            walk_q.state <= W_IDLE;
        end else begin
            walk_q <= walk_d;
        end
    end

    assign ar_addr_o  = walk_q.ptr & ~ALIGN_MASK;
    assign ar_len_o   = 8'(BEATS - 1);
    assign ar_size_o  = 3'(SIZE);
    assign ar_burst_o = 2'b01;
    assign req_desc_o = cur_desc;
    assign busy_o     = (walk_q.state != W_IDLE);

    assert_ar_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ar_valid_o && !ar_ready_i) |=> (ar_valid_o && $stable(ar_addr_o)));

    assert_req_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_desc_o)));

    // Data beats are only taken after an address handshake (R3).
    assert_beat_after_addr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(r_ready_o) |-> $past(ar_valid_o && ar_ready_i));

endmodule

// File: rtl/dlist_fetch.sv
module dlist_fetch
    import dlist_pkg::*;
#(
    parameter int DATA_W      = 64,
    parameter int NSPEC       = 4,
    parameter int START_DEPTH = 8
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                start_we_i,
    input  logic [63:0]         start_addr_i,
    output logic                stat_busy_o,
    output logic                stat_err_o,
    output logic                ar_valid_o,
    input  logic                ar_ready_i,
    output logic [63:0]         ar_addr_o,
    output logic [7:0]          ar_len_o,
    output logic [2:0]          ar_size_o,
    output logic [1:0]          ar_burst_o,
    input  logic                r_valid_i,
    output logic                r_ready_o,
    input  logic [DATA_W-1:0]   r_data_i,
    output logic                req_valid_o,
    input  logic                req_ready_i,
    output logic [63:0]         req_src_o,
    output logic [63:0]         req_dst_o,
    output logic [31:0]         req_len_o,
    output logic [7:0]          req_id_o,
    output logic [15:0]         req_cfg_o,
    input  logic                done_i,
    output logic                irq_o
);
    localparam int PEND_DEPTH = NSPEC + 1;
    localparam int PCW        = $clog2(PEND_DEPTH + 1);
    localparam int SCW        = $clog2(START_DEPTH + 1);
    localparam logic [PCW-1:0] SPEC_LIM = PCW'(NSPEC);

    top_regs_t   regs_q, regs_d;
    dlist_desc_t desc;

    logic               st_push, st_pop, st_empty, st_full;
    logic [63:0]        st_head;
    logic [SCW-1:0]     unused_st_cnt;
    logic               pd_push, pd_pop, pd_empty, pd_full_unused, pd_head;
    logic [PCW-1:0]     pd_cnt;
    logic               fetch_ok, walk_busy, start_nz;
    logic [7:0]         unused_rsv;

    assign start_nz = (start_addr_i != '0);
    assign st_push  = start_we_i && start_nz && !st_full;

    dlist_fifo #(.WIDTH(64), .DEPTH(START_DEPTH)) i_start_q (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .push_i  (st_push),
        .data_i  (start_addr_i),
        .pop_i   (st_pop),
        .data_o  (st_head),
        .empty_o (st_empty),
        .full_o  (st_full),
        .count_o (unused_st_cnt)
    );

    assign fetch_ok = (pd_cnt <= SPEC_LIM);

    dlist_walker #(.DATA_W(DATA_W)) i_walker (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .start_valid_i (!st_empty),
        .start_addr_i  (st_head),
        .start_pop_o   (st_pop),
        .fetch_ok_i    (fetch_ok),
        .ar_valid_o    (ar_valid_o),
        .ar_ready_i    (ar_ready_i),
        .ar_addr_o     (ar_addr_o),
        .ar_len_o      (ar_len_o),
        .ar_size_o     (ar_size_o),
        .ar_burst_o    (ar_burst_o),
        .r_valid_i     (r_valid_i),
        .r_data_i      (r_data_i),
        .r_ready_o     (r_ready_o),
        .req_valid_o   (req_valid_o),
        .req_ready_i   (req_ready_i),
        .req_desc_o    (desc),
        .busy_o        (walk_busy)
    );

    assign pd_push = req_valid_o && req_ready_i;
    assign pd_pop  = done_i && !pd_empty;

    dlist_fifo #(.WIDTH(1), .DEPTH(PEND_DEPTH)) i_pend_q (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .push_i  (pd_push),
        .data_i  (desc.flags[0]),
        .pop_i   (pd_pop),
        .data_o  (pd_head),
        .empty_o (pd_empty),
        .full_o  (pd_full_unused),
        .count_o (pd_cnt)
    );

    always_comb begin
        regs_d     = regs_q;
        regs_d.irq = pd_pop && pd_head;
        if (start_we_i && start_nz && st_full) regs_d.err = 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) regs_q <= '0;
        else         regs_q <= regs_d;
    end

    assign req_src_o   = desc.src;
    assign req_dst_o   = desc.dst;
    assign req_len_o   = desc.len;
    assign req_id_o    = desc.flags[23:16];
    assign req_cfg_o   = desc.flags[15:0];
    assign unused_rsv  = desc.flags[31:24];
    assign irq_o       = regs_q.irq;
    assign stat_err_o  = regs_q.err;
    assign stat_busy_o = walk_busy || !st_empty || !pd_empty;

    assert_spec_limit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ar_valid_o |-> (pd_cnt <= SPEC_LIM));

    assert_irq_after_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> $past(done_i));

    assert_err_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stat_err_o |=> stat_err_o);

    assert_idle_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !stat_busy_o |-> (!ar_valid_o && !req_valid_o));

endmodule

// File: tb/test_dlist_fetch.sv
module test_dlist_fetch;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 64;
    localparam logic [63:0] ENDP = 64'hFFFF_FFFF_FFFF_FFFF;

    logic clk, rst_n;
    logic start_we; logic [63:0] start_addr;
    logic stat_busy, stat_err;
    logic ar_valid, ar_ready; logic [63:0] ar_addr;
    logic [7:0] ar_len; logic [2:0] ar_size; logic [1:0] ar_burst;
    logic r_valid, r_ready; logic [DW-1:0] r_data;
    logic req_valid, req_ready;
    logic [63:0] req_src, req_dst; logic [31:0] req_len;
    logic [7:0] req_id; logic [15:0] req_cfg;
    logic done, irq;

    int total = 0;
    int bad = 0;
    logic [63:0] mem [0:255];
    logic [63:0] ar_log [0:63];
    logic [7:0]  last_len; logic [2:0] last_size; logic [1:0] last_burst;
    logic [63:0] rq_src [0:63]; logic [63:0] rq_dst [0:63];
    logic [31:0] rq_len [0:63]; logic [7:0] rq_id [0:63]; logic [15:0] rq_cfg [0:63];
    int ar_n, req_n, done_n;
    logic be_hold;

    dlist_fetch i_dlist_fetch (
        .clk_i(clk), .rst_ni(rst_n),
        .start_we_i(start_we), .start_addr_i(start_addr),
        .stat_busy_o(stat_busy), .stat_err_o(stat_err),
        .ar_valid_o(ar_valid), .ar_ready_i(ar_ready), .ar_addr_o(ar_addr),
        .ar_len_o(ar_len), .ar_size_o(ar_size), .ar_burst_o(ar_burst),
        .r_valid_i(r_valid), .r_ready_o(r_ready), .r_data_i(r_data),
        .req_valid_o(req_valid), .req_ready_i(req_ready),
        .req_src_o(req_src), .req_dst_o(req_dst), .req_len_o(req_len),
        .req_id_o(req_id), .req_cfg_o(req_cfg),
        .done_i(done), .irq_o(irq)
    );

    initial begin
        clk = 1'b0;
        forever #(CLK_PERIOD/2) clk = ~clk;
    end

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", rq, act, exp);
        end
    endtask

    // Memory read slave: one burst of four beats per address handshake.
    initial begin
        ar_ready = 1'b0; r_valid = 1'b0; r_data = '0;
        forever begin
            @(negedge clk);
            if (ar_valid) begin
                ar_log[ar_n] = ar_addr;
                last_len = ar_len; last_size = ar_size; last_burst = ar_burst;
                ar_n++;
                ar_ready = 1'b1;
                @(negedge clk);
                ar_ready = 1'b0;
                for (int b = 0; b < 4; b++) begin
                    r_valid = 1'b1;
                    r_data  = mem[ar_log[ar_n-1][10:3] + 8'(b)];
                    @(negedge clk);
                end
                r_valid = 1'b0;
            end
        end
    end

    // Backend model: accept requests unless held, log them.
    initial begin
        req_ready = 1'b0;
        forever begin
            @(negedge clk);
            req_ready = !be_hold;
            if (req_valid && req_ready) begin
                rq_src[req_n] = req_src; rq_dst[req_n] = req_dst;
                rq_len[req_n] = req_len; rq_id[req_n] = req_id; rq_cfg[req_n] = req_cfg;
                req_n++;
            end
        end
    end

    task automatic put_desc(input logic [63:0] a, input logic [63:0] dst, input logic [63:0] src,
                            input logic [63:0] nxt, input logic [31:0] len, input logic [31:0] flags);
        mem[a[10:3]]        = dst;
        mem[a[10:3] + 8'd1] = src;
        mem[a[10:3] + 8'd2] = nxt;
        mem[a[10:3] + 8'd3] = {flags, len};
    endtask

    task automatic apply_reset();
        rst_n = 1'b0; start_we = 1'b0; start_addr = '0; done = 1'b0; be_hold = 1'b0;
        repeat (3) @(negedge clk);
        ar_n = 0; req_n = 0; done_n = 0;
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic write_start(input logic [63:0] a);
        @(negedge clk);
        start_we = 1'b1; start_addr = a;
        @(negedge clk);
        start_we = 1'b0; start_addr = '0;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
        done_n++;
    endtask

    task automatic drain();
        for (int k = 0; k < 3000 && stat_busy; k++) begin
            if (req_n > done_n) pulse_done();
            else @(negedge clk);
        end
    endtask

    task automatic t_reset();
        apply_reset();
        chk("R1 busy", stat_busy, 0);
        chk("R1 err", stat_err, 0);
        chk("R1 ar_valid", ar_valid, 0);
        chk("R1 req_valid", req_valid, 0);
        chk("R1 irq", irq, 0);
    endtask

    task automatic t_zero_write();
        apply_reset();
        write_start(64'h0);
        repeat (10) @(negedge clk);
        chk("R11 busy after zero write", stat_busy, 0);
        chk("R11 no fetch", ar_n, 0);
    endtask

    task automatic t_single();
        apply_reset();
        put_desc(64'h100, 64'h1111_2222_3333_4440, 64'hAAAA_BBBB_CCCC_DDD0, ENDP, 32'h40, 32'hA512_3C07);
        put_desc(64'h140, 64'h1111_2222_3333_4440, 64'hAAAA_BBBB_CCCC_DDD0, ENDP, 32'h40, 32'h0012_3C07);
        write_start(64'h10B);
        repeat (30) @(negedge clk);
        chk("R2 one burst", ar_n, 1);
        chk("R2 aligned addr", ar_log[0], 64'h100);
        chk("R2 len", last_len, 3);
        chk("R2 size", last_size, 3);
        chk("R2 burst", last_burst, 1);
        chk("R3 dst", rq_dst[0], 64'h1111_2222_3333_4440);
        chk("R3 src", rq_src[0], 64'hAAAA_BBBB_CCCC_DDD0);
        chk("R3 len", rq_len[0], 32'h40);
        chk("R4 id", rq_id[0], 8'h12);
        chk("R4 cfg", rq_cfg[0], 16'h3C07);
        chk("R6 stop at end", req_n, 1);
        chk("R9 busy in transfer", stat_busy, 1);
        chk("R8 no early irq", irq, 0);
        pulse_done();
        chk("R8 irq pulse", irq, 1);
        @(negedge clk);
        chk("R8 irq one cycle", irq, 0);
        chk("R9 idle at end", stat_busy, 0);
        write_start(64'h140);
        repeat (30) @(negedge clk);
        chk("R4 reserved ignored id", rq_id[1], rq_id[0]);
        chk("R4 reserved ignored cfg", rq_cfg[1], rq_cfg[0]);
        drain();
    endtask

    task automatic t_chain();
        apply_reset();
        put_desc(64'h200, 64'h5000, 64'h6000, 64'h240, 32'd1, 32'h0000_0001);
        put_desc(64'h240, 64'h5100, 64'h6100, 64'h280, 32'd2, 32'h0000_0000);
        put_desc(64'h280, 64'h5200, 64'h6200, ENDP,    32'd3, 32'h0000_0001);
        write_start(64'h200);
        repeat (60) @(negedge clk);
        chk("R6 three fetches", ar_n, 3);
        chk("R6 second addr", ar_log[1], 64'h240);
        chk("R6 third addr", ar_log[2], 64'h280);
        chk("R6 order len0", rq_len[0], 1);
        chk("R6 order len2", rq_len[2], 3);
        pulse_done();
        chk("R8 irq first", irq, 1);
        pulse_done();
        chk("R8 no irq second", irq, 0);
        pulse_done();
        chk("R8 irq third", irq, 1);
        @(negedge clk);
        chk("R9 chain idle", stat_busy, 0);
    endtask

    task automatic t_spec();
        apply_reset();
        for (int i = 0; i < 7; i++) begin
            logic [63:0] a;
            a = 64'h400 + 64'(i) * 64'h20;
            put_desc(a, 64'h8000 + a, 64'h9000 + a, (i < 6) ? a + 64'h20 : ENDP, 32'(16 * (i + 1)), 32'h0);
        end
        write_start(64'h400);
        repeat (150) @(negedge clk);
        chk("R7 fetches capped", ar_n, 5);
        chk("R7 requests capped", req_n, 5);
        chk("R9 busy while pending", stat_busy, 1);
        pulse_done();
        repeat (40) @(negedge clk);
        chk("R7 one more after done", ar_n, 6);
        drain();
        chk("R6 all issued", req_n, 7);
        chk("R6 last len", rq_len[6], 112);
        chk("R9 idle", stat_busy, 0);
    endtask

    task automatic t_hold();
        logic [63:0] snap;
        apply_reset();
        be_hold = 1'b1;
        put_desc(64'h100, 64'h7700, 64'h7800, ENDP, 32'h20, 32'h0);
        write_start(64'h100);
        repeat (30) @(negedge clk);
        chk("R5 valid while stalled", req_valid, 1);
        snap = req_src;
        repeat (5) @(negedge clk);
        chk("R5 still valid", req_valid, 1);
        chk("R5 src stable", req_src, snap);
        chk("R5 not taken", req_n, 0);
        be_hold = 1'b0;
        repeat (5) @(negedge clk);
        chk("R5 taken after release", req_n, 1);
        drain();
    endtask

    task automatic t_queue();
        apply_reset();
        be_hold = 1'b1;
        put_desc(64'h100, 64'h7700, 64'h7800, ENDP, 32'h20, 32'h0);
        write_start(64'h100);
        repeat (10) @(negedge clk);
        for (int i = 0; i < 8; i++) write_start(64'h100);
        chk("R10 no error when room", stat_err, 0);
        write_start(64'h100);
        chk("R10 overflow flagged", stat_err, 1);
        be_hold = 1'b0;
        drain();
        chk("R10 queued chains run", req_n, 9);
        chk("R10 error sticky", stat_err, 1);
        chk("R9 idle after queue", stat_busy, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start_we = 1'b0; start_addr = '0; done = 1'b0; be_hold = 1'b0;
        ar_n = 0; req_n = 0; done_n = 0;
        t_reset();
        t_zero_write();
        t_single();
        t_chain();
        t_spec();
        t_hold();
        t_queue();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule